// File: doc/BRIEF.md
# Presence-Vector Coherence Directory

This block is the home-side directory of a small shared-memory multiprocessor. For every memory block it owns, it keeps one entry made of two state bits and a presence vector. A set home bit means no cache holds the block, and the vector is then ignored. A clear home bit with the shared bit set means read-only copies exist, and each set vector bit marks a holder. A clear home bit with the shared bit clear means exactly one vector bit names the owner of a writable copy. The entry is therefore 2 + VEC_W bits wide.

A requester sends a read miss, a write miss or a writeback for one block. The controller reads the entry from a synchronous RAM, works out the new entry, writes it back and returns a response. The response carries a grant code, a per-processor invalidate mask and a per-processor mask of caches that must supply their data. With `GROUP` above 1, one presence bit stands for `GROUP` consecutive processors. Both masks then name every processor of a marked group, except the requester. Only one request is in flight at a time. After reset, the controller walks the whole RAM to set every entry to the home state before it accepts work.

Top module: `dir_controller`

## Requirements
- R1: After reset, `reqReady` stays low for NUM_BLOCKS rising edges while every entry is set to the home state. It then goes high, and every block reads as home.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both high. `reqReady` is low during the following cycle. `rspValid` is high for exactly one cycle, the one after the second rising edge counted from acceptance.
- R3: A read miss (op 0) on a home entry returns grant 0 (shared) with both masks zero. The entry becomes shared, holding only the requester's group bit.
- R4: A read miss on a shared entry returns grant 0 with both masks zero, and adds the requester's group bit to the vector.
- R5: A read miss on an exclusive entry returns grant 0. The fetch mask covers the owner group's processors except the requester, and the invalidate mask is zero. The entry becomes shared with both the owner and the requester groups marked.
- R6: A write miss (op 1) on a home entry returns grant 1 (exclusive) with both masks zero. The entry becomes exclusive to the requester's group.
- R7: A write miss on a shared entry returns grant 1. The invalidate mask covers every processor in a marked group except the requester, and the fetch mask is zero. The entry becomes exclusive to the requester's group.
- R8: A write miss on an exclusive entry returns grant 1. The invalidate mask and the fetch mask are both the owner group's processors except the requester. The entry becomes exclusive to the requester's group.
- R9: A writeback (op 2) on an exclusive entry whose owner bit is the requester's group returns grant 2 with both masks zero. The entry returns to home with the vector cleared.
- R10: A writeback in any other case, or reserved op 3, returns grant 3 (reject) with both masks zero. The entry is left unchanged.
- R11: Mask bit p corresponds to presence bit p / GROUP, so a marked group yields one mask bit per processor in it.
- R12: Neither mask ever contains the requester, and both masks are zero while `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqOp | input | 2 | 0 read miss, 1 write miss, 2 writeback, 3 reserved |
| reqBlock | input | $clog2(NUM_BLOCKS) | Block number |
| reqId | input | $clog2(NUM_PROCS) | Requesting processor |
| rspValid | output | 1 | One-cycle response strobe |
| rspGrant | output | 2 | 0 shared, 1 exclusive, 2 writeback accepted, 3 rejected |
| rspInv | output | NUM_PROCS | Processors that must invalidate |
| rspFetch | output | NUM_PROCS | Processors that must supply data |

## Verification
The bench runs with two processors per presence bit, so group expansion and requester exclusion are tested together. A single block is driven through every state: reads that grow the sharer set, a write that invalidates several groups, a read that recalls an exclusive copy, and a write that steals ownership. These separate the per-state transitions. Writebacks from a non-owner, on a home entry and on a shared entry, plus a reserved op, show that rejection leaves the entry untouched. A read after an accepted writeback shows the vector was cleared. A same-group read on a second block, and back-to-back requests, cover the case where the owner and the requester share one presence bit, and check pipelined ordering through the RAM.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WBACK = 2'd2,
    OP_RSVD  = 2'd3
  } dirOpE;

  typedef enum logic [1:0] {
    GNT_SHARED = 2'd0,
    GNT_EXCL   = 2'd1,
    GNT_WBACK  = 2'd2,
    GNT_REJECT = 2'd3
  } dirGrantE;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_LOOK  = 2'd2
  } dirStateE;

  typedef struct packed {
    logic sweep;
    logic capture;
    logic commit;
  } dirStrobeS;

endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      sweepDone,
  output logic      reqReady,
  output dirStrobeS stb
);

  dirStateE state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_CLEAR;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    reqReady    = 1'b0;
    unique case (state)
      ST_CLEAR: begin
        stb.sweep = 1'b1;
        if (sweepDone) stateNxt = ST_IDLE;
      end
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          stateNxt    = ST_LOOK;
        end
      end
      ST_LOOK: begin
        stb.commit = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_CLEAR;
    endcase
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_PROCS  = 8,
  parameter int GROUP      = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dirStrobeS                     stb,
  input  logic [1:0]                    reqOp,
  input  logic [$clog2(NUM_BLOCKS)-1:0] reqBlock,
  input  logic [$clog2(NUM_PROCS)-1:0]  reqId,
  output logic                          sweepDone,
  output logic                          rspValid,
  output logic [1:0]                    rspGrant,
  output logic [NUM_PROCS-1:0]          rspInv,
  output logic [NUM_PROCS-1:0]          rspFetch
);

  localparam int VEC_W  = NUM_PROCS / GROUP;
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int ID_W   = $clog2(NUM_PROCS);
  localparam int ENT_W  = VEC_W + 2;
  localparam int HOME_B = VEC_W + 1;
  localparam int SHR_B  = VEC_W;
  localparam int GRP_SH = $clog2(GROUP);
  localparam logic [ENT_W-1:0] HOME_ENT = {1'b1, 1'b0, {VEC_W{1'b0}}};

  logic [ENT_W-1:0] mem [NUM_BLOCKS];
  logic [ENT_W-1:0] rdData, nxtEntry;
  logic [BLK_W-1:0] blkQ, sweepIdx;
  logic [ID_W-1:0]  idQ, grpIdx;
  dirOpE            opQ;

  logic             curHome, curShr, exclState;
  logic [VEC_W-1:0] curVec, grpHot;
  logic [NUM_PROCS-1:0] curExp, reqHot, othersExp, nxtInv, nxtFetch;
  dirGrantE         nxtGrant;

  // Entry RAM: init sweep or one read-modify-write per request
  always_ff @(posedge clk) begin
    if (stb.sweep)       mem[sweepIdx] <= HOME_ENT;
    else if (stb.commit) mem[blkQ]     <= nxtEntry;
  end

  always_ff @(posedge clk) begin
    if (stb.capture) rdData <= mem[reqBlock];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkQ     <= '0;
      idQ      <= '0;
      opQ      <= OP_READ;
      sweepIdx <= '0;
    end else begin
      if (stb.sweep) sweepIdx <= sweepIdx + 1'b1;
      if (stb.capture) begin
        blkQ <= reqBlock;
        idQ  <= reqId;
        opQ  <= dirOpE'(reqOp);
      end
    end
  end

  assign sweepDone = stb.sweep && (sweepIdx == BLK_W'(NUM_BLOCKS - 1));

  // Decode of the looked-up entry
  assign curHome   = rdData[HOME_B];
  assign curShr    = rdData[SHR_B];
  assign curVec    = rdData[VEC_W-1:0];
  assign exclState = !curHome && !curShr;
  assign grpIdx    = idQ >> GRP_SH;

  always_comb begin
    for (int g = 0; g < VEC_W; g++) grpHot[g] = (int'(grpIdx) == g);
    for (int p = 0; p < NUM_PROCS; p++) reqHot[p] = (int'(idQ) == p);
  end

  // One presence bit fans out to GROUP processors
  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_expand
    assign curExp[p] = curVec[p / GROUP];
  end

  assign othersExp = curExp & ~reqHot;

  always_comb begin
    nxtEntry = rdData;
    nxtInv   = '0;
    nxtFetch = '0;
    nxtGrant = GNT_REJECT;
    unique case (opQ)
      OP_READ: begin
        nxtGrant = GNT_SHARED;
        nxtEntry = {1'b0, 1'b1, (curHome ? grpHot : (curVec | grpHot))};
        if (exclState) nxtFetch = othersExp;
      end
      OP_WRITE: begin
        nxtGrant = GNT_EXCL;
        nxtEntry = {2'b00, grpHot};
        if (!curHome)  nxtInv   = othersExp;
        if (exclState) nxtFetch = othersExp;
      end
      OP_WBACK: begin
        if (exclState && |(curVec & grpHot)) begin
          nxtGrant = GNT_WBACK;
          nxtEntry = HOME_ENT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= GNT_SHARED;
      rspInv   <= '0;
      rspFetch <= '0;
    end else begin
      rspValid <= stb.commit;
      rspGrant <= stb.commit ? nxtGrant : GNT_SHARED;
      rspInv   <= stb.commit ? nxtInv   : '0;
      rspFetch <= stb.commit ? nxtFetch : '0;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R2
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspInv == '0 && rspFetch == '0)); // R12
  AST_NO_SELF: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (((rspInv | rspFetch) & reqHot) == '0)); // R12
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && exclState) |-> $onehot(curVec)); // R8
  AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspGrant == GNT_WBACK) |-> (rspInv == '0 && rspFetch == '0)); // R9

endmodule

// File: rtl/dir_controller.sv
module dir_controller #(
  parameter int NUM_BLOCKS = 16,
  parameter int NUM_PROCS  = 8,
  parameter int GROUP      = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [1:0]                    reqOp,
  input  logic [$clog2(NUM_BLOCKS)-1:0] reqBlock,
  input  logic [$clog2(NUM_PROCS)-1:0]  reqId,
  output logic                          rspValid,
  output logic [1:0]                    rspGrant,
  output logic [NUM_PROCS-1:0]          rspInv,
  output logic [NUM_PROCS-1:0]          rspFetch
);

  dir_pkg::dirStrobeS stb;
  logic sweepDone;

  dir_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .sweepDone (sweepDone),
    .reqReady  (reqReady),
    .stb       (stb)
  );

  dir_datapath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_PROCS  (NUM_PROCS),
    .GROUP      (GROUP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqOp     (reqOp),
    .reqBlock  (reqBlock),
    .reqId     (reqId),
    .sweepDone (sweepDone),
    .rspValid  (rspValid),
    .rspGrant  (rspGrant),
    .rspInv    (rspInv),
    .rspFetch  (rspFetch)
  );

endmodule

// File: tb/dir_controller_tb.sv
`timescale 1ns/1ps
module dir_controller_tb;

  localparam int NB = 8;
  localparam int NP = 8;
  localparam int GP = 2;
  localparam int VW = NP / GP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [$clog2(NB)-1:0] reqBlock = '0;
  logic [$clog2(NP)-1:0] reqId = '0;
  logic reqReady, rspValid;
  logic [1:0] rspGrant;
  logic [NP-1:0] rspInv, rspFetch;

  always #2 clk = ~clk;

  dir_controller #(.NUM_BLOCKS(NB), .NUM_PROCS(NP), .GROUP(GP)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBlock(reqBlock), .reqId(reqId),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspInv(rspInv), .rspFetch(rspFetch)
  );

  int compared = 0;
  int mismatched = 0;
  int negCount = 0;
  int due = -10;
  bit monOn = 1'b0;

  bit mHome [NB];
  bit mShr  [NB];
  bit [VW-1:0] mVec [NB];

  logic [1:0] expGrant;
  logic [NP-1:0] expInv, expFetch;
  string expTag;

  task automatic predict(input int op, input int blk, input int id);
    bit [NP-1:0] others;
    bit excl;
    int g;
    g = id / GP;
    excl = !mHome[blk] && !mShr[blk];
    for (int p = 0; p < NP; p++) others[p] = mVec[blk][p / GP] && (p != id);
    expInv = '0; expFetch = '0;
    if (op == 0) begin
      expGrant = 2'd0;
      expTag = mHome[blk] ? "R3" : (mShr[blk] ? "R4" : "R5");
      if (excl) expFetch = others;
      if (mHome[blk]) mVec[blk] = '0;
      mVec[blk][g] = 1'b1;
      mHome[blk] = 1'b0; mShr[blk] = 1'b1;
    end else if (op == 1) begin
      expGrant = 2'd1;
      expTag = mHome[blk] ? "R6" : (mShr[blk] ? "R7" : "R8");
      if (!mHome[blk]) expInv = others;
      if (excl) expFetch = others;
      mVec[blk] = '0; mVec[blk][g] = 1'b1;
      mHome[blk] = 1'b0; mShr[blk] = 1'b0;
    end else if (op == 2 && excl && mVec[blk][g]) begin
      expGrant = 2'd2; expTag = "R9";
      mHome[blk] = 1'b1; mShr[blk] = 1'b0; mVec[blk] = '0;
    end else begin
      expGrant = 2'd3; expTag = "R10";
    end
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference comparison every clock
  always @(negedge clk) begin
    if (monOn) begin
      negCount++;
      check("R2", "rspValid", 32'(rspValid), 32'(negCount == due));
      if (negCount == due - 1) check("R2", "reqReady busy", 32'(reqReady), 32'd0);
      if (negCount == due) begin
        check(expTag, "grant", 32'(rspGrant), 32'(expGrant));
        check(expTag, "inv mask R11 R12", 32'(rspInv), 32'(expInv));
        check(expTag, "fetch mask R11 R12", 32'(rspFetch), 32'(expFetch));
      end else begin
        check("R12", "idle masks", 32'(rspInv | rspFetch), 32'd0);
      end
      if (reqValid && reqReady) begin
        predict(int'(reqOp), int'(reqBlock), int'(reqId));
        due = negCount + 2;
      end
    end
  end

  // Called just after a rising edge
  task automatic doReq(input int op, input int blk, input int id);
    reqOp = 2'(op); reqBlock = 3'(blk); reqId = 3'(id);
    reqValid = 1'b1;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog: actual hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mHome[b] = 1'b1; mShr[b] = 1'b0; mVec[b] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset rspValid", 32'(rspValid), 32'd0);
    check("R1", "reset reqReady", 32'(reqReady), 32'd0);
    rstN = 1'b1;
    repeat (NB - 1) @(posedge clk);
    @(negedge clk);
    check("R1", "reqReady during sweep", 32'(reqReady), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R1", "reqReady after sweep", 32'(reqReady), 32'd1);
    monOn = 1'b1;
    @(posedge clk); #1;

    // Block 0 through every state (groups: {0,1},{2,3},{4,5},{6,7})
    doReq(0, 0, 0);   // R3 home read
    doReq(0, 0, 5);   // R4 add sharer
    doReq(1, 0, 1);   // R7 R11 invalidate 0,4,5
    gap(2);
    doReq(0, 0, 6);   // R5 recall from group 0
    doReq(1, 0, 6);   // R7 invalidate 0,1,7
    doReq(1, 0, 2);   // R8 steal from group 3
    doReq(2, 0, 4);   // R10 non-owner writeback
    doReq(2, 0, 3);   // R9 owner group writeback
    doReq(2, 0, 3);   // R10 writeback on home
    doReq(0, 0, 7);   // R9 vector cleared: only group 3
    // Block 3: owner and requester in one group
    doReq(1, 3, 0);   // R6 home write
    doReq(0, 3, 1);   // R5 fetch from processor 0 only
    doReq(3, 3, 1);   // R10 reserved op
    doReq(2, 3, 0);   // R10 writeback on shared
    doReq(1, 3, 4);   // R7 invalidate 0,1
    // Last block: R1 swept entry is home
    doReq(1, NB - 1, 4); // R6
    doReq(0, NB - 1, 5); // R5
    doReq(0, NB - 1, 2); // R4
    gap(6);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule